// File: doc/BRIEF.md
# Per-Bit Change Detector

This block watches a wide synchronous input vector and reports, bit by bit, which positions have changed value since they were last seen. Each lane keeps a stored reference value. On every rising clock edge the lane compares its input with that reference using XOR. A mismatch is a change: the lane then raises its own sticky event flag and loads the new input value as its reference. A lane whose input matches keeps its reference as it is.

The flags are not cleared automatically. The user pulses a synchronous clear strobe at the start of each observation interval. A change that arrives in the same cycle as the clear is not lost. A single summary output reports that at least one flag is set. The reference register starts at zero after reset, so any input bit that is 1 in the first sample after reset counts as a change.

Top module: `chg_bit_monitor`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it falls, `flag_o` reads all zeros and `any_o` reads 0. This holds whatever value `din_i` has.
- R2: If `din_i[i]` differs from lane i's stored reference at a rising edge, `flag_o[i]` reads 1 after that edge.
- R3: The reference of every lane is 0 after reset. A bit that is 1 in the first sample after reset therefore sets its flag.
- R4: A lane loads its reference only when that lane changes. Once the reference is loaded, holding the same input leaves the flag clear after a clear strobe. Returning to the earlier value sets the flag again.
- R5: A set flag stays at 1 on every edge where `clr_i` is 0, even if the input returns to its earlier value.
- R6: When `clr_i` is 1 at a rising edge, every lane that did not change at that edge reads 0 after the edge.
- R7: When `clr_i` is 1 and lane i changes at the same edge, `flag_o[i]` reads 1 after the edge.
- R8: `any_o` is 1 exactly when at least one bit of `flag_o` is 1. It therefore stays high until a clear strobe.
- R9: A change on one lane never sets the flag of any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; sampling on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | WIDTH | Monitored vector |
| clr_i | input | 1 | Synchronous clear strobe for all flags |
| flag_o | output | WIDTH | Sticky per-bit event flags |
| any_o | output | 1 | High when any flag is set |

## Verification
The bench builds the block with the default width of 64 and a summary group size of 8. With these values the OR-reduction tree has several leaf groups and a final stage, so a flag in any group reaches the summary output. A walking one across all 64 lanes exercises every lane and every group boundary. A pseudo-random sequence then mixes simultaneous multi-bit changes, returns to earlier values and clears that coincide with changes.

// File: rtl/chg_pkg.sv
package chg_pkg;

  // A lane has changed when its input differs from its stored reference.
  function automatic logic lane_hit(input logic d, input logic r);
    return d ^ r;
  endfunction

  // A sticky flag: a change sets it, a clear drops it, a change wins over a clear.
  function automatic logic lane_next_flag(input logic f, input logic hit, input logic clr);
    return hit | (f & ~clr);
  endfunction

  // The reference is loaded only on a change.
  function automatic logic lane_next_ref(input logic r, input logic d, input logic hit);
    return hit ? d : r;
  endfunction

  function automatic int unsigned num_groups(input int unsigned width, input int unsigned grp);
    return (width + grp - 1) / grp;
  endfunction

endpackage

// File: rtl/chg_ref_bank.sv
module chg_ref_bank #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] ref_o,
  output logic [WIDTH-1:0] hit_o
);
  import chg_pkg::*;

  logic [WIDTH-1:0] ref_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign hit_o[i] = lane_hit(din_i[i], ref_q[i]);
    always_ff @(posedge clk_i) begin
      if (rst_i) ref_q[i] <= 1'b0;
      else       ref_q[i] <= lane_next_ref(ref_q[i], din_i[i], hit_o[i]);
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/chg_flag_bank.sv
module chg_flag_bank #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] hit_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o
);
  import chg_pkg::*;

  logic [WIDTH-1:0] flag_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (rst_i) flag_q[i] <= 1'b0;
      else       flag_q[i] <= lane_next_flag(flag_q[i], hit_i[i], clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/chg_summary.sv
module chg_summary #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned GROUP = 8
) (
  input  logic [WIDTH-1:0] flag_i,
  output logic             any_o
);
  import chg_pkg::*;

  localparam int unsigned NGRP = num_groups(WIDTH, GROUP);
  localparam int unsigned PADW = NGRP * GROUP;

  logic [PADW-1:0] padded;
  logic [NGRP-1:0] grp_any;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = flag_i;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign any_o = |grp_any;
endmodule

// File: rtl/chg_bit_monitor.sv
module chg_bit_monitor #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned GROUP = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o,
  output logic             any_o
);
  logic [WIDTH-1:0] ref_w;
  logic [WIDTH-1:0] hit_w;

  chg_ref_bank #(.WIDTH(WIDTH)) u_ref (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .din_i (din_i),
    .ref_o (ref_w),
    .hit_o (hit_w)
  );

  chg_flag_bank #(.WIDTH(WIDTH)) u_flag (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hit_i  (hit_w),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );

  chg_summary #(.WIDTH(WIDTH), .GROUP(GROUP)) u_sum (
    .flag_i (flag_o),
    .any_o  (any_o)
  );
endmodule

// File: rtl/chg_bit_monitor_chk.sv
module chg_bit_monitor_chk #(
  parameter int unsigned WIDTH = 64
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [WIDTH-1:0] din_i,
  input logic             clr_i,
  input logic [WIDTH-1:0] flag_o,
  input logic             any_o,
  input logic [WIDTH-1:0] ref_w,
  input logic [WIDTH-1:0] hit_w
);
  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (flag_o == '0) && (ref_w == '0)); // R1

  AST_CHANGE_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> ((flag_o & $past(hit_w)) == $past(hit_w))); // R2

  AST_REF_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && hit_w == '0) |=> $stable(ref_w)); // R4

  AST_REF_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (ref_w == $past(din_i))); // R4

  AST_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && !clr_i) |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R5

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && clr_i) |=> ((flag_o & ~$past(hit_w)) == '0)); // R6

  AST_ANY_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && !clr_i && any_o) |=> any_o); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> ((flag_o & ~$past(flag_o) & ~$past(hit_w)) == '0)); // R9
endmodule

bind chg_bit_monitor chg_bit_monitor_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .din_i  (din_i),
  .clr_i  (clr_i),
  .flag_o (flag_o),
  .any_o  (any_o),
  .ref_w  (ref_w),
  .hit_w  (hit_w)
);

// File: tb/tb_chg_bit_monitor.sv
module tb_chg_bit_monitor;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] din;
  logic         clr;
  logic [W-1:0] flag;
  logic         any;

  chg_bit_monitor #(.WIDTH(W), .GROUP(8)) dut (
    .clk_i(clk), .rst_i(rst), .din_i(din), .clr_i(clr),
    .flag_o(flag), .any_o(any)
  );

  always #4 clk = ~clk; // 125 MHz

  // Behavioural model: remembers the last input per bit and a sticky set.
  bit    last_seen [W];
  bit    exp_f     [W];
  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (rst) begin
        last_seen[i] = 1'b0;
        exp_f[i]     = 1'b0;
      end else begin
        bit changed;
        changed = (din[i] != last_seen[i]);
        if (changed) exp_f[i] = 1'b1;
        else if (clr) exp_f[i] = 1'b0;
        last_seen[i] = din[i];
      end
    end
  end

  task automatic compare();
    logic [W-1:0] ev;
    logic         ea;
    ea = 1'b0;
    for (int i = 0; i < W; i++) begin
      ev[i] = exp_f[i];
      if (exp_f[i]) ea = 1'b1;
    end
    vectors++;
    if (flag !== ev || any !== ea) begin
      miscompares++;
      $display("FAIL %s flags=%h exp=%h any=%b exp=%b", cur_req, flag, ev, any, ea);
    end
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step(input logic [W-1:0] d, input logic c);
    @(negedge clk);
    compare();
    din = d;
    clr = c;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] lfsr;
    rst = 1'b1; clr = 1'b0; din = 64'hDEAD_BEEF_0123_4567;
    cur_req = "R1";
    repeat (3) step(din, 1'b0);
    @(negedge clk); compare(); rst = 1'b0;      // values change after the next edge
    cur_req = "R3";                             // first sample flags the ones in din
    step(din, 1'b0);
    cur_req = "R5";
    step(64'h0, 1'b0);                          // return to zero, flags stay
    step(64'h0, 1'b0);
    cur_req = "R6";
    step(64'h0, 1'b1);
    step(64'h0, 1'b0);
    cur_req = "R2";
    step(64'h0000_0000_0001_0000, 1'b0);
    step(64'h0000_0000_0001_0000, 1'b0);
    cur_req = "R4";                             // held value, clear: no re-flag
    step(64'h0000_0000_0001_0000, 1'b1);
    step(64'h0000_0000_0001_0000, 1'b0);
    step(64'h0000_0000_0001_0000, 1'b0);
    step(64'h0, 1'b0);                          // back to old value: flag again
    step(64'h0, 1'b0);
    cur_req = "R7";
    step(64'h8000_0000_0000_0001, 1'b1);        // change together with clear
    step(64'h8000_0000_0000_0001, 1'b0);
    cur_req = "R8";
    step(64'h8000_0000_0000_0001, 1'b1);
    step(64'h8000_0000_0000_0001, 1'b0);
    step(64'h8000_0000_0000_0001, 1'b0);
    cur_req = "R9";                             // walking one with clears
    for (int b = 0; b < W; b++) begin
      step(64'h8000_0000_0000_0001 ^ (64'h1 << b), 1'b1);
      step(64'h8000_0000_0000_0001 ^ (64'h1 << b), 1'b0);
    end
    cur_req = "R2";
    lfsr = 64'hACE1_2468_1357_BDF0;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      step((n % 3 == 0) ? din : (din ^ (lfsr & (lfsr >> 7))), (lfsr[5:3] == 3'b101));
    end
    cur_req = "R6";
    step(din, 1'b1);
    step(din, 1'b0);
    step(din, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule